// File: doc/BRIEF.md
# Nanosecond Time-of-Day Counter

This block keeps the reference time for a packet timestamping unit. The time is one flat 64-bit count of nanoseconds. On every clock cycle in which the clock is running, the block adds a programmable increment to the time. The increment has an integer nanosecond part and a 32-bit fraction, so the block can follow clock periods that are not a whole number of nanoseconds, such as 1.6 ns. The sub-nanosecond remainder is carried from one cycle to the next, so no rounding error builds up over time.

Software reaches the block through a 32-bit register port. Each 64-bit quantity is split into a low word and a high word, and a few ordering rules make each access atomic:
- Reading the low time word captures the upper half of the time at that moment.
- Writing the low word of the time or of the increment only stages it. The high-word write applies the full 64-bit value in one cycle.

A link-speed code and a load strobe give a quick way to install the default increment for the current link rate. While the link runs at 100 Mb/s the clock stands still.

Top module: `tod_clock`

## Requirements
- R1: After reset the time is 0, the fraction is 0, the in-use increment is 0x1_99999999 (integer word 1, fraction word 0x99999999), the run bit is 0 and reg_rdata is 0.
- R2: When the run bit is set and link_speed is not 3'd1, each rising clock edge adds the increment to a 96-bit accumulator. The upper 64 bits form the time and the lower 32 bits form the fraction. The fraction is carried from cycle to cycle, and the time wraps modulo 2^64.
- R3: While the run bit (bit 0 at address 0) is clear, the time and the fraction hold their values.
- R4: While link_speed equals 3'd1 (100 Mb/s), the time holds even when the run bit is set. It resumes on the first edge at which the code differs.
- R5: A write to address 1 (time low) only stages the word and leaves time_ns unchanged. A write to address 2 (time high) loads {written word, staged low word} into the time and clears the fraction, starting in the next cycle. A load wins over the increment step in the same cycle.
- R6: A read of address 1 returns bits 31:0 of the time at that edge and captures bits 63:32 into a shadow register. A read of address 2 returns the shadow register, whatever the time has done since then.
- R7: A write to address 3 (increment fraction) only stages the word, and the in-use increment does not change. A write to address 4 (increment integer nanoseconds) commits {written word, staged fraction} as the in-use increment.
- R8: A one-cycle speed_load pulse installs a default increment chosen by link_speed:
  - 3'd2 gives 0x20_00000000.
  - 3'd3 gives 0x3_33333333.
  - 3'd0, 3'd4 and any other code give 0x1_99999999.
  - 3'd1 leaves the increment unchanged.
  - A register commit in the same cycle takes priority over the pulse.
- R9: Read data appears on reg_rdata one cycle after the reg_rd strobe and holds until the next read. The readable addresses are:
  - 0: the run bit in bit 0.
  - 3: the in-use fraction.
  - 4: the in-use integer part.
  - Any unmapped address (5 to 7) reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| link_speed | input | 3 | Link rate code (0 none, 1 100M, 2 1G, 3 10G, 4 40G) |
| speed_load | input | 1 | Pulse that installs the default increment for link_speed |
| time_ns | output | 64 | Current time in nanoseconds |

## Verification
A corrupted fraction cannot be seen directly. It shows up as a whole-nanosecond error in time_ns only after enough steps have accumulated, so the bench runs 1.6 ns steps over 5 and then 15 edges and compares the exact carried result. A wrong staged word or a wrong shadow shows up on the very next high-word access, either as a wrong loaded time or as a wrong read value. A wrong in-use increment shows up one cycle after a commit through the increment read-back, and in the slope of time_ns during the following run.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
    localparam int TOD_DATA_W = 32;
    localparam int TOD_ADDR_W = 3;
    localparam int TOD_SPD_W  = 3;

    // link rate codes
    localparam logic [TOD_SPD_W-1:0] SPD_NONE = 3'd0;
    localparam logic [TOD_SPD_W-1:0] SPD_100M = 3'd1;
    localparam logic [TOD_SPD_W-1:0] SPD_1G   = 3'd2;
    localparam logic [TOD_SPD_W-1:0] SPD_10G  = 3'd3;
    localparam logic [TOD_SPD_W-1:0] SPD_40G  = 3'd4;

    // increments: {integer ns [63:32], fraction [31:0]}
    localparam logic [63:0] INC_FAST = 64'h0000_0001_9999_9999;
    localparam logic [63:0] INC_MID  = 64'h0000_0003_3333_3333;
    localparam logic [63:0] INC_SLOW = 64'h0000_0020_0000_0000;

    function automatic logic [63:0] speed_default(input logic [TOD_SPD_W-1:0] spd);
        logic [63:0] v;
        case (spd)
            SPD_1G:  v = INC_SLOW;
            SPD_10G: v = INC_MID;
            default: v = INC_FAST;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/tod_regif.sv
`timescale 1ns/1ps
module tod_regif
    import tod_pkg::*;
#(
    parameter int DATA_W = TOD_DATA_W,
    parameter int ADDR_W = TOD_ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [2*DATA_W-1:0]   time_ns,
    input  logic [2*DATA_W-1:0]   inc_cur,
    output logic                  run_en,
    output logic                  time_load,
    output logic [2*DATA_W-1:0]   time_load_val,
    output logic                  inc_commit,
    output logic [2*DATA_W-1:0]   inc_commit_val
);
    localparam int WIDE_W = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_TIME_LO = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_TIME_HI = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_INC_LO  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_INC_HI  = ADDR_W'(4);

    typedef struct packed {
        logic              run;
        logic [DATA_W-1:0] time_lo_stg;
        logic [DATA_W-1:0] inc_lo_stg;
        logic [DATA_W-1:0] time_hi_shadow;
        logic [DATA_W-1:0] rdata;
    } regif_st_t;

    regif_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        time_load      = 1'b0;
        inc_commit     = 1'b0;
        time_load_val  = {wdata, st_q.time_lo_stg};
        inc_commit_val = {wdata, st_q.inc_lo_stg};
        if (wr_en) begin
            case (addr)
                A_CTRL:    st_d.run         = wdata[0];
                A_TIME_LO: st_d.time_lo_stg = wdata;
                A_TIME_HI: time_load        = 1'b1;
                A_INC_LO:  st_d.inc_lo_stg  = wdata;
                A_INC_HI:  inc_commit       = 1'b1;
                default: ;
            endcase
        end
        if (rd_en) begin
            case (addr)
                A_CTRL:    st_d.rdata = {{(DATA_W-1){1'b0}}, st_q.run};
                A_TIME_LO: begin
                    st_d.rdata          = time_ns[DATA_W-1:0];
                    st_d.time_hi_shadow = time_ns[WIDE_W-1:DATA_W];
                end
                A_TIME_HI: st_d.rdata = st_q.time_hi_shadow;
                A_INC_LO:  st_d.rdata = inc_cur[DATA_W-1:0];
                A_INC_HI:  st_d.rdata = inc_cur[WIDE_W-1:DATA_W];
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_en = st_q.run;
    assign rdata  = st_q.rdata;

    // R6: low-word read captures the upper half of the time seen at that edge
    a_r6_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_TIME_LO) |=> st_q.time_hi_shadow == $past(time_ns[WIDE_W-1:DATA_W]));

    // R9: read data holds when no read is issued
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R6: shadow only moves on a low-word read
    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == A_TIME_LO) |=> $stable(st_q.time_hi_shadow));
endmodule

// File: rtl/tod_incsel.sv
`timescale 1ns/1ps
module tod_incsel
    import tod_pkg::*;
#(
    parameter int INC_W = 2 * TOD_DATA_W,
    parameter int SPD_W = TOD_SPD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_load,
    input  logic [SPD_W-1:0]  link_speed,
    input  logic              commit,
    input  logic [INC_W-1:0]  commit_val,
    output logic [INC_W-1:0]  inc,
    output logic              clk_stop
);
    typedef struct packed {
        logic [INC_W-1:0] inc;
    } incsel_st_t;

    incsel_st_t st_d, st_q;
    logic       slow_link;

    assign slow_link = (link_speed == SPD_100M);

    always_comb begin
        st_d = st_q;
        if (commit)
            st_d.inc = commit_val;
        else if (speed_load && !slow_link)
            st_d.inc = INC_W'(speed_default(link_speed));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.inc <= INC_W'(INC_FAST);
        else        st_q     <= st_d;
    end

    assign inc      = st_q.inc;
    assign clk_stop = slow_link;

    // R7: in-use increment is untouched without a commit or speed load
    a_r7_inc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !speed_load) |=> $stable(inc));

    // R8: a register commit wins over a speed load in the same cycle
    a_r8_commit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> inc == $past(commit_val));

    // R8: 100M speed load leaves the increment alone
    a_r8_slow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && link_speed == SPD_100M) |=> $stable(inc));
endmodule

// File: rtl/tod_accum.sv
`timescale 1ns/1ps
module tod_accum
    import tod_pkg::*;
#(
    parameter int NS_W   = 2 * TOD_DATA_W,
    parameter int FRAC_W = TOD_DATA_W,
    parameter int INC_W  = 2 * TOD_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic [NS_W-1:0]   load_ns,
    input  logic [INC_W-1:0]  inc,
    output logic [NS_W-1:0]   time_ns
);
    localparam int ACC_W = NS_W + FRAC_W;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } accum_st_t;

    accum_st_t st_d, st_q;
    logic [ACC_W-1:0] sum;

    assign sum = {st_q.ns, st_q.frac} + ACC_W'(inc);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ns   = load_ns;
            st_d.frac = '0;
        end else if (run) begin
            {st_d.ns, st_d.frac} = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_ns = st_q.ns;

    // R5: a load sets the time and clears the fraction
    a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.ns == $past(load_ns)) && (st_q.frac == '0));

    // R3: stopped clock holds both time and fraction
    a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(st_q.ns) && $stable(st_q.frac));
endmodule

// File: rtl/tod_clock.sv
`timescale 1ns/1ps
module tod_clock
    import tod_pkg::*;
#(
    parameter int DATA_W = TOD_DATA_W,
    parameter int ADDR_W = TOD_ADDR_W,
    parameter int SPD_W  = TOD_SPD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [SPD_W-1:0]      link_speed,
    input  logic                  speed_load,
    output logic [2*DATA_W-1:0]   time_ns
);
    localparam int NS_W  = 2 * DATA_W;
    localparam int INC_W = 2 * DATA_W;

    logic             run_en, clk_stop, run_q_gate;
    logic             time_load, inc_commit;
    logic [NS_W-1:0]  time_load_val;
    logic [INC_W-1:0] inc_commit_val, inc_cur;

    tod_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (reg_wr),
        .rd_en          (reg_rd),
        .addr           (reg_addr),
        .wdata          (reg_wdata),
        .rdata          (reg_rdata),
        .time_ns        (time_ns),
        .inc_cur        (inc_cur),
        .run_en         (run_en),
        .time_load      (time_load),
        .time_load_val  (time_load_val),
        .inc_commit     (inc_commit),
        .inc_commit_val (inc_commit_val)
    );

    tod_incsel #(.INC_W(INC_W), .SPD_W(SPD_W)) u_incsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .speed_load (speed_load),
        .link_speed (link_speed),
        .commit     (inc_commit),
        .commit_val (inc_commit_val),
        .inc        (inc_cur),
        .clk_stop   (clk_stop)
    );

    assign run_q_gate = run_en && !clk_stop;

    tod_accum #(.NS_W(NS_W), .FRAC_W(DATA_W), .INC_W(INC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q_gate),
        .load    (time_load),
        .load_ns (time_load_val),
        .inc     (inc_cur),
        .time_ns (time_ns)
    );

    // R4: 100M link freezes the time unless software loads it
    a_r4_slow_link_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (link_speed == SPD_100M && !time_load) |=> $stable(time_ns));
endmodule

// File: tb/tod_clock_bench.sv
`timescale 1ns/1ps
module tod_clock_bench;
    localparam logic [2:0] AD_CTRL = 3'd0;
    localparam logic [2:0] AD_TLO  = 3'd1;
    localparam logic [2:0] AD_THI  = 3'd2;
    localparam logic [2:0] AD_ILO  = 3'd3;
    localparam logic [2:0] AD_IHI  = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, speed_load = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  link_speed = 3'd4;
    logic [63:0] time_ns;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    tod_clock u_tod_clock (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .link_speed (link_speed),
        .speed_load (speed_load),
        .time_ns    (time_ns)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks are entered at a falling edge and return at a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic spd(input logic [2:0] s);
        link_speed = s; speed_load = 1'b1;
        @(negedge clk);
        speed_load = 1'b0;
    endtask

    // n increment steps: enable edge adds nothing, disable edge adds one
    task automatic run_steps(input int n);
        wr(AD_CTRL, 32'd1);
        repeat (n - 1) @(negedge clk);
        wr(AD_CTRL, 32'd0);
    endtask

    function automatic logic [63:0] model(input logic [63:0] start, input logic [63:0] inc, input int n);
        logic [95:0] acc;
        acc = {start, 32'h0} + 96'(n) * 96'(inc);
        return acc[95:32];
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 time", time_ns, 64'h0);
        chk("R1 rdata", 64'(reg_rdata), 64'h0);
        rd(AD_CTRL, d); chk("R1 ctrl", 64'(d), 64'h0);
        rd(AD_ILO, d);  chk("R1 inc frac", 64'(d), 64'h9999_9999);
        rd(AD_IHI, d);  chk("R1 inc int", 64'(d), 64'h1);
    endtask

    task automatic t_load;
        wr(AD_TLO, 32'h89AB_CDEF);
        chk("R5 low write staged only", time_ns, 64'h0);
        wr(AD_THI, 32'h0123_4567);
        chk("R5 high write loads", time_ns, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_latch;
        logic [31:0] d;
        rd(AD_TLO, d); chk("R6 low read", 64'(d), 64'h89AB_CDEF);
        wr(AD_TLO, 32'h0);
        wr(AD_THI, 32'h55);
        chk("R5 reload", time_ns, 64'h55_0000_0000);
        rd(AD_THI, d); chk("R6 shadow kept", 64'(d), 64'h0123_4567);
        rd(AD_TLO, d); chk("R6 low read 2", 64'(d), 64'h0);
        rd(AD_THI, d); chk("R6 shadow new", 64'(d), 64'h55);
    endtask

    task automatic t_inc_commit;
        logic [31:0] d;
        wr(AD_ILO, 32'h8000_0000);
        rd(AD_ILO, d); chk("R7 frac staged only", 64'(d), 64'h9999_9999);
        wr(AD_IHI, 32'd2);
        rd(AD_ILO, d); chk("R7 frac committed", 64'(d), 64'h8000_0000);
        rd(AD_IHI, d); chk("R7 int committed", 64'(d), 64'h2);
    endtask

    task automatic t_run;
        wr(AD_TLO, 32'h0); wr(AD_THI, 32'h0);
        run_steps(4);
        chk("R2 2.5ns x4", time_ns, 64'd10);
        repeat (5) @(negedge clk);
        chk("R3 stopped holds", time_ns, 64'd10);
    endtask

    task automatic t_frac;
        spd(3'd4);
        wr(AD_TLO, 32'h0); wr(AD_THI, 32'h0);
        run_steps(5);
        chk("R2 1.6ns x5", time_ns, model(64'h0, 64'h1_9999_9999, 5));
        run_steps(10);
        chk("R2 1.6ns x15 carry", time_ns, model(64'h0, 64'h1_9999_9999, 15));
    endtask

    task automatic t_speed;
        logic [31:0] d;
        spd(3'd2);
        rd(AD_IHI, d); chk("R8 1G int", 64'(d), 64'h20);
        rd(AD_ILO, d); chk("R8 1G frac", 64'(d), 64'h0);
        spd(3'd3);
        rd(AD_IHI, d); chk("R8 10G int", 64'(d), 64'h3);
        rd(AD_ILO, d); chk("R8 10G frac", 64'(d), 64'h3333_3333);
        spd(3'd1);
        rd(AD_ILO, d); chk("R8 100M unchanged", 64'(d), 64'h3333_3333);
        spd(3'd7);
        rd(AD_IHI, d); chk("R8 other code int", 64'(d), 64'h1);
        rd(AD_ILO, d); chk("R8 other code frac", 64'(d), 64'h9999_9999);
        wr(AD_ILO, 32'h11);
        link_speed = 3'd2; speed_load = 1'b1;
        reg_wr = 1'b1; reg_addr = AD_IHI; reg_wdata = 32'h7;
        @(negedge clk);
        reg_wr = 1'b0; speed_load = 1'b0; link_speed = 3'd4;
        rd(AD_IHI, d); chk("R8 commit wins int", 64'(d), 64'h7);
        rd(AD_ILO, d); chk("R8 commit wins frac", 64'(d), 64'h11);
    endtask

    task automatic t_wrap;
        wr(AD_ILO, 32'h0); wr(AD_IHI, 32'h1);
        wr(AD_TLO, 32'hFFFF_FFFE); wr(AD_THI, 32'hFFFF_FFFF);
        run_steps(3);
        chk("R2 wrap", time_ns, 64'd1);
    endtask

    task automatic t_slow_link;
        link_speed = 3'd1;
        wr(AD_CTRL, 32'd1);
        repeat (5) @(negedge clk);
        chk("R4 100M frozen", time_ns, 64'd1);
        link_speed = 3'd4;
        repeat (2) @(negedge clk);
        wr(AD_CTRL, 32'd0);
        chk("R4 resumes", time_ns, 64'd4);
    endtask

    task automatic t_map;
        logic [31:0] d;
        rd(AD_IHI, d);
        repeat (3) @(negedge clk);
        chk("R9 rdata holds", 64'(reg_rdata), 64'h1);
        rd(3'd6, d); chk("R9 unmapped zero", 64'(d), 64'h0);
        wr(AD_CTRL, 32'd1);
        rd(AD_CTRL, d); chk("R9 ctrl readback", 64'(d), 64'h1);
        wr(AD_CTRL, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_latch();
        t_inc_commit();
        t_run();
        t_frac();
        t_speed();
        t_wrap();
        t_slow_link();
        t_map();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule